// File: doc/BRIEF.md
# Cell Header Error Control Receiver

This block checks the five-byte header of each received fixed-size cell against its 8-bit CRC check byte and decides, under a two-mode policy, whether the header is passed through, repaired or thrown away. A header arrives as one 40-bit word with a valid strobe. The block computes the syndrome of all 40 bits in one combinational pass and compares it against a computed table of the 40 single-bit error syndromes. One clock later it presents the result header, a deliver flag and the policy mode.

The policy keeps memory between cells. While the receiver trusts the line, it is in correction mode and repairs a header that has exactly one bad bit. After any error, it falls back to a detection-only mode that discards every damaged header. It leaves that mode only when a clean header arrives. A downstream stage uses the deliver flag to keep or drop the cell payload that travels alongside the header.

Top module: `hec_rx`

## Requirements
- R1: After reset, and for as long as reset is held, `res_vld_o` is 0 and `mode_o` is 0, which means correction mode (1 means detection mode).
- R2: The header layout is fixed. Bits [39:8] carry the 32 protected header bits, with bit 39 the first bit on the line. Bits [7:0] carry the check byte, which is the remainder of those 32 bits times x^8 divided by x^8 + x^2 + x + 1. In correction mode, a header whose check byte matches is delivered unchanged (`deliver_o` = 1) and the mode stays correction.
- R3: In correction mode, a header with exactly one flipped bit, at any of the 40 positions, is delivered with that bit restored, and the mode changes to detection.
- R4: In correction mode, a header with two flipped bits is discarded (`deliver_o` = 0), and the mode changes to detection.
- R5: In detection mode, a header with one or more flipped bits is discarded, and the mode stays detection.
- R6: In detection mode, a header whose check byte matches is delivered unchanged, and the mode returns to correction.
- R7: `res_vld_o` is 1 in the cycle after each cycle with `hdr_vld_i` = 1, and 0 in the cycle after each cycle without it. Back-to-back strobes give back-to-back results.
- R8: While `hdr_vld_i` is 0, `hdr_i` is ignored and the mode does not change.
- R9: For a discarded header, `hdr_o` carries the received header without any change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_vld_i | input | 1 | Header strobe |
| hdr_i | input | 40 | Received header, check byte in bits [7:0] |
| res_vld_o | output | 1 | Result valid, one cycle after the strobe |
| hdr_o | output | 40 | Header after correction, or the raw header on discard |
| deliver_o | output | 1 | 1 = deliver the cell, 0 = discard it |
| mode_o | output | 1 | Policy mode: 0 = correction, 1 = detection |

## Verification
Every result, and the mode that the header moves the policy into, is due exactly one clock after the strobe edge. The path is one combinational syndrome and locate stage followed by one register. The bench drives inputs on the falling edge and checks `res_vld_o`, `hdr_o`, `deliver_o` and `mode_o` on the next falling edge. This lets back-to-back vectors be checked each cycle. Idle gaps and resets are checked on the falling edges in between, where no result may appear and the mode must not move.

// File: rtl/hec_rx_pkg.sv
package hec_rx_pkg;

    localparam int CRC_W = 8;

    typedef enum logic {
        MODE_CORR = 1'b0,
        MODE_DET  = 1'b1
    } mode_e;

    // Remainder of x^pos modulo the generator (low CRC_W bits given in poly).
    function automatic logic [CRC_W-1:0] pos_syndrome(input int pos,
                                                       input logic [CRC_W-1:0] poly);
        logic [CRC_W-1:0] r;
        logic             top;
        r = {{(CRC_W-1){1'b0}}, 1'b1};
        for (int k = 0; k < pos; k++) begin
            top = r[CRC_W-1];
            r   = r << 1;
            if (top) r = r ^ poly;
        end
        return r;
    endfunction

endpackage

// File: rtl/hec_syndrome.sv
module hec_syndrome
    import hec_rx_pkg::*;
#(
    parameter int                 HDR_W = 40,
    parameter logic [CRC_W-1:0]   POLY  = 8'h07
) (
    input  logic [HDR_W-1:0] hdr_i,
    output logic [CRC_W-1:0] syn_o
);

    logic [CRC_W-1:0] term [HDR_W];

    // Each set bit contributes its own x^i mod g.
    for (genvar i = 0; i < HDR_W; i++) begin : g_term
        localparam logic [CRC_W-1:0] SYN_I = pos_syndrome(i, POLY);
        assign term[i] = hdr_i[i] ? SYN_I : '0;
    end

    always_comb begin
        syn_o = '0;
        for (int i = 0; i < HDR_W; i++) begin
            syn_o = syn_o ^ term[i];
        end
    end

endmodule

// File: rtl/hec_locator.sv
module hec_locator
    import hec_rx_pkg::*;
#(
    parameter int                 HDR_W = 40,
    parameter logic [CRC_W-1:0]   POLY  = 8'h07
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [HDR_W-1:0] hdr_i,
    input  logic [CRC_W-1:0] syn_i,
    output logic             syn_zero_o,
    output logic             single_o,
    output logic [HDR_W-1:0] fixed_o
);

    logic [HDR_W-1:0] hit;

    // Syndrome table: one comparator per bit position.
    for (genvar i = 0; i < HDR_W; i++) begin : g_cmp
        localparam logic [CRC_W-1:0] SYN_I = pos_syndrome(i, POLY);
        assign hit[i] = (syn_i == SYN_I);
    end

    assign syn_zero_o = (syn_i == '0);
    assign single_o   = |hit;
    assign fixed_o    = hdr_i ^ hit;

    // R3: at most one bit may ever be repaired
    one_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

    // R2: a clean syndrome never selects a repair position
    clean_no_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        syn_zero_o |-> (fixed_o == hdr_i));

endmodule

// File: rtl/hec_policy.sv
module hec_policy
    import hec_rx_pkg::*;
#(
    parameter int HDR_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld_i,
    input  logic [HDR_W-1:0] raw_i,
    input  logic [HDR_W-1:0] fixed_i,
    input  logic             syn_zero_i,
    input  logic             single_i,
    output logic             res_vld_o,
    output logic [HDR_W-1:0] hdr_o,
    output logic             deliver_o,
    output logic             mode_o
);

    typedef struct packed {
        mode_e            mode;
        logic             vld;
        logic             deliver;
        logic [HDR_W-1:0] hdr;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = vld_i;
        if (vld_i) begin
            st_d.hdr     = raw_i;
            st_d.deliver = 1'b0;
            unique case (st_q.mode)
                MODE_CORR: begin
                    if (syn_zero_i) begin
                        st_d.deliver = 1'b1;
                    end else if (single_i) begin
                        st_d.deliver = 1'b1;
                        st_d.hdr     = fixed_i;
                        st_d.mode    = MODE_DET;
                    end else begin
                        st_d.mode    = MODE_DET;
                    end
                end
                MODE_DET: begin
                    if (syn_zero_i) begin
                        st_d.deliver = 1'b1;
                        st_d.mode    = MODE_CORR;
                    end
                end
                default: st_d.mode = MODE_CORR;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_CORR, vld: 1'b0, deliver: 1'b0, hdr: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign res_vld_o = st_q.vld;
    assign hdr_o     = st_q.hdr;
    assign deliver_o = st_q.deliver;
    assign mode_o    = st_q.mode;

    // R7
    strobe_to_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |=> res_vld_o);

    // R7
    no_strobe_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> !res_vld_o);

    // R8
    idle_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> $stable(mode_o));

    // R3
    corr_single_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && mode_o == MODE_CORR && !syn_zero_i && single_i)
        |=> (deliver_o && mode_o == MODE_DET));

    // R4
    corr_multi_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && mode_o == MODE_CORR && !syn_zero_i && !single_i)
        |=> (!deliver_o && mode_o == MODE_DET));

    // R5
    det_error_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && mode_o == MODE_DET && !syn_zero_i)
        |=> (!deliver_o && mode_o == MODE_DET));

    // R6
    det_clean_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && mode_o == MODE_DET && syn_zero_i)
        |=> (deliver_o && mode_o == MODE_CORR));

    // R9
    drop_keeps_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |=> (deliver_o || hdr_o == $past(raw_i)));

endmodule

// File: rtl/hec_rx.sv
module hec_rx
    import hec_rx_pkg::*;
#(
    parameter int                 HDR_W = 40,
    parameter logic [CRC_W-1:0]   POLY  = 8'h07
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hdr_vld_i,
    input  logic [HDR_W-1:0] hdr_i,
    output logic             res_vld_o,
    output logic [HDR_W-1:0] hdr_o,
    output logic             deliver_o,
    output logic             mode_o
);

    logic [CRC_W-1:0] syn;
    logic             syn_zero;
    logic             single;
    logic [HDR_W-1:0] fixed;

    hec_syndrome #(.HDR_W(HDR_W), .POLY(POLY)) u_syn (
        .hdr_i (hdr_i),
        .syn_o (syn)
    );

    hec_locator #(.HDR_W(HDR_W), .POLY(POLY)) u_loc (
        .clk        (clk),
        .rst_n      (rst_n),
        .hdr_i      (hdr_i),
        .syn_i      (syn),
        .syn_zero_o (syn_zero),
        .single_o   (single),
        .fixed_o    (fixed)
    );

    hec_policy #(.HDR_W(HDR_W)) u_pol (
        .clk        (clk),
        .rst_n      (rst_n),
        .vld_i      (hdr_vld_i),
        .raw_i      (hdr_i),
        .fixed_i    (fixed),
        .syn_zero_i (syn_zero),
        .single_i   (single),
        .res_vld_o  (res_vld_o),
        .hdr_o      (hdr_o),
        .deliver_o  (deliver_o),
        .mode_o     (mode_o)
    );

endmodule

// File: tb/hec_rx_tb_top.sv
module hec_rx_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hdr_vld_i = 1'b0;
    logic [39:0] hdr_i = '0;
    logic        res_vld_o;
    logic [39:0] hdr_o;
    logic        deliver_o;
    logic        mode_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hec_rx dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .hdr_vld_i (hdr_vld_i),
        .hdr_i     (hdr_i),
        .res_vld_o (res_vld_o),
        .hdr_o     (hdr_o),
        .deliver_o (deliver_o),
        .mode_o    (mode_o)
    );

    typedef struct packed {
        logic [31:0] pay;
        logic [39:0] err;
        logic        dlv;
        logic        mode_after;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0000, 40'h00_0000_0000, 1'b1, 1'b0},  // R2 clean, correction
        '{32'h1234_5678, 40'h80_0000_0000, 1'b1, 1'b1},  // R3 bit 39
        '{32'hDEAD_BEEF, 40'h00_0000_0000, 1'b1, 1'b0},  // R6 clean, detection
        '{32'hA5A5_0F0F, 40'h00_0010_0400, 1'b0, 1'b1},  // R4 two bits
        '{32'h0BAD_F00D, 40'h00_0000_0001, 1'b0, 1'b1},  // R5 single bit in check byte
        '{32'h7777_1111, 40'h03_0000_0000, 1'b0, 1'b1},  // R5 two bits
        '{32'hFFFF_FFFF, 40'h00_0000_0000, 1'b1, 1'b0},  // R6 clean
        '{32'hC0FF_EE00, 40'h00_0010_0000, 1'b1, 1'b1},  // R3 bit 20
        '{32'h0000_0001, 40'h00_0000_0000, 1'b1, 1'b0},  // R6 clean
        '{32'h8000_0000, 40'h00_0000_0001, 1'b1, 1'b1},  // R3 bit 0
        '{32'h1357_9BDF, 40'h00_0000_0080, 1'b0, 1'b1},  // R5 bit 7
        '{32'h2468_ACE0, 40'h00_0000_0000, 1'b1, 1'b0},  // R6 clean
        '{32'h5555_AAAA, 40'h00_0000_0000, 1'b1, 1'b0},  // R2 clean
        '{32'h0F1E_2D3C, 40'h00_0000_0180, 1'b0, 1'b1}   // R4 bits 7 and 8
    };

    function automatic logic [7:0] crc8(input logic [31:0] d);
        logic [7:0] r = '0;
        logic       fb;
        for (int i = 31; i >= 0; i--) begin
            fb = d[i] ^ r[7];
            r  = {r[6:0], 1'b0};
            if (fb) r = r ^ 8'h07;
        end
        return r;
    endfunction

    function automatic string tag_of(input logic mode_before, input logic [39:0] err,
                                     input logic dlv);
        if (err == '0) return mode_before ? "R6" : "R2";
        if (mode_before) return "R5";
        return dlv ? "R3" : "R4";
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic        mode_model;
        logic [39:0] clean;
        @(negedge clk);
        // R1: state during reset
        check("R1", "res_vld in reset", 64'(res_vld_o), 64'd0);
        check("R1", "mode in reset", 64'(mode_o), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "mode after reset", 64'(mode_o), 64'd0);
        check("R7", "no result without strobe", 64'(res_vld_o), 64'd0);

        // Table walk, one vector per cycle
        mode_model = 1'b0;
        for (int k = 0; k < NV; k++) begin
            clean     = {VECS[k].pay, crc8(VECS[k].pay)};
            hdr_i     = clean ^ VECS[k].err;
            hdr_vld_i = 1'b1;
            @(negedge clk);
            check(tag_of(mode_model, VECS[k].err, VECS[k].dlv), "deliver",
                  64'(deliver_o), 64'(VECS[k].dlv));
            check(tag_of(mode_model, VECS[k].err, VECS[k].dlv), "mode",
                  64'(mode_o), 64'(VECS[k].mode_after));
            check("R7", "result valid", 64'(res_vld_o), 64'd1);
            if (VECS[k].dlv)
                check(tag_of(mode_model, VECS[k].err, VECS[k].dlv), "header",
                      64'(hdr_o), 64'(clean));
            else
                check("R9", "raw header kept", 64'(hdr_o), 64'(clean ^ VECS[k].err));
            mode_model = VECS[k].mode_after;
        end

        // R8: idle with garbage input while in detection mode
        hdr_vld_i = 1'b0;
        for (int k = 0; k < 5; k++) begin
            hdr_i = {8'hA0 + 8'(k), 32'h0};
            @(negedge clk);
            check("R8", "mode held while idle", 64'(mode_o), 64'd1);
            check("R7", "no result while idle", 64'(res_vld_o), 64'd0);
        end

        // R3 over every bit position, each followed by a clean header
        for (int p = 0; p < 40; p++) begin
            clean     = {32'h3C5A_0000 + 32'(p), crc8(32'h3C5A_0000 + 32'(p))};
            hdr_i     = clean;
            hdr_vld_i = 1'b1;
            @(negedge clk);
            check("R6", "clean return", 64'(mode_o), 64'd0);
            hdr_i = clean ^ (40'd1 << p);
            @(negedge clk);
            check("R3", "every position fixed", 64'(hdr_o), 64'(clean));
            check("R3", "every position delivered", 64'(deliver_o), 64'd1);
            check("R3", "every position mode", 64'(mode_o), 64'd1);
        end
        hdr_vld_i = 1'b0;

        // R1: mid-run reset from detection mode
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1", "mode on reset", 64'(mode_o), 64'd0);
        check("R1", "res_vld on reset", 64'(res_vld_o), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // After reset a single-bit error is corrected again
        clean     = {32'h0101_0101, crc8(32'h0101_0101)};
        hdr_i     = clean ^ 40'h00_0000_4000;
        hdr_vld_i = 1'b1;
        @(negedge clk);
        hdr_vld_i = 1'b0;
        check("R3", "fix after reset", 64'(hdr_o), 64'(clean));
        check("R3", "deliver after reset", 64'(deliver_o), 64'd1);
        @(negedge clk);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule